// File: doc/BRIEF.md
# Programmable Level Flag Unit for a Dual-Clock FIFO

This block produces the two programmable watermark flags of a dual-clock FIFO. The almost-full flag sits in the write clock domain. The almost-empty flag sits in the read clock domain. Each flag compares a level count, which the surrounding FIFO already holds in the right domain, against an offset register. The write-side threshold is the offset Y, compared against the free-location count. The read-side threshold is the offset X, compared against the stored-word count. Both flags are active low. They stay asserted until the offsets have been programmed.

The offsets are programmed after reset by one of three methods. The method is taken from the configuration pins on the first write-clock edge after reset is released. The preset method loads a fixed value into both offsets at once. The parallel method takes the first two enabled writes from the write data bus. The serial method shifts one chained bit stream through Y and then X. Until programming completes, write enables are not passed on to the FIFO memory.

Top module: `fifo_level_flags`

## Requirements
- R1: While rst_ni is low, af_n_o, ae_n_o and prog_done_o are all 0.
- R2: cfg_ext_i and cfg_sel_i are sampled only on the first wclk_i rising edge after reset is released. Later changes on these pins have no effect on the method or on the offsets.
- R3: When cfg_ext_i=0 at capture, both offsets load a preset on the capture edge, and prog_done_o rises on that same edge. The preset depends on cfg_sel_i: 0 gives 8, 1 gives 16, and 2 or 3 gives 64.
- R4: When cfg_ext_i=1 and cfg_sel_i[0]=0 (parallel), the first wr_en_i after the capture edge loads Y from wdata_i[OFS_W-1:0]. The second loads X from the same bits and sets prog_done_o.
- R5: fifo_wr_o equals wr_en_i while prog_done_o=1 and is 0 otherwise. The writes consumed by parallel programming never reach the FIFO.
- R6: When cfg_ext_i=1 and cfg_sel_i[0]=1 (serial), each wclk_i rising edge with sen_ni=0 shifts in sdata_i. There are 2*OFS_W bits in all. The first bit lands in the MSB of Y and the last bit in the LSB of X. prog_done_o is set on the edge of the last bit.
- R7: Once prog_done_o is 1, it stays 1 until reset. Further serial or parallel activity leaves the offsets unchanged.
- R8: On each wclk_i edge, af_n_o loads 0 if programming was not done before that edge. Otherwise it loads 0 when wr_free_i <= Y and 1 when wr_free_i > Y.
- R9: On each rclk_i edge, ae_n_o loads 0 until prog_done_o, passed through a two-stage synchronizer, reads 1. After that it loads 0 when rd_used_i <= X and 1 when rd_used_i > X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_ext_i | input | 1 | 0: preset method; 1: external load |
| cfg_sel_i | input | 2 | Preset choice, or bit 0 selects serial (1) versus parallel (0) |
| wr_en_i | input | 1 | Write request from the write port |
| wdata_i | input | DATA_W | Write data bus |
| sen_ni | input | 1 | Serial shift enable, active low |
| sdata_i | input | 1 | Serial offset data |
| wr_free_i | input | OFS_W+1 | Free locations, write domain |
| rd_used_i | input | OFS_W+1 | Stored words, read domain |
| fifo_wr_o | output | 1 | Write forwarded to FIFO memory |
| prog_done_o | output | 1 | Offsets programmed (write domain) |
| af_n_o | output | 1 | Almost-full flag, active low |
| ae_n_o | output | 1 | Almost-empty flag, active low |

## Verification
The assertions assume three things about the inputs. First, prog_done_o never falls outside reset. Second, the level inputs stay within 0 to DEPTH. Third, X is stable in the write domain before the synchronized done bit reaches the read domain. The stimulus keeps within these limits. It drives both clocks from one source, so the crossing behaves like a coincident clock. It draws level counts only from the range 0 to DEPTH. It changes the configuration pins only around reset, or on purpose after capture, to show that such changes are ignored.

// File: rtl/fifo_level_flags_pkg.sv
package fifo_level_flags_pkg;
  typedef enum logic [1:0] {
    LOAD_PRESET   = 2'd0,
    LOAD_PARALLEL = 2'd1,
    LOAD_SERIAL   = 2'd2
  } load_mode_e;

  localparam int unsigned PRESET_LO  = 8;
  localparam int unsigned PRESET_MID = 16;
  localparam int unsigned PRESET_HI  = 64;
endpackage

// File: rtl/fifo_level_sync.sv
module fifo_level_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/fifo_level_cmp.sv
module fifo_level_cmp #(
  parameter int unsigned OFS_W = 10,
  localparam int unsigned CNT_W = OFS_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] level_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             flag_no
);
  logic flag_q;

  // high only when level strictly exceeds the offset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= en_i && (level_i > {1'b0, ofs_i});
  end

  assign flag_no = flag_q;
endmodule

// File: rtl/fifo_level_loader.sv
module fifo_level_loader
  import fifo_level_flags_pkg::*;
#(
  parameter int unsigned OFS_W = 10,
  localparam int unsigned NBITS  = 2 * OFS_W,
  localparam int unsigned BITS_W = $clog2(NBITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_ext_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic             wr_en_i,
  input  logic [OFS_W-1:0] wdata_i,
  input  logic             sen_ni,
  input  logic             sdata_i,
  output logic [OFS_W-1:0] y_o,
  output logic [OFS_W-1:0] x_o,
  output logic             done_o
);
  localparam logic [BITS_W-1:0] LAST_BIT = BITS_W'(NBITS - 1);

  logic              locked_q, half_q, done_q;
  load_mode_e        mode_q;
  logic [OFS_W-1:0]  y_q, x_q;
  logic [BITS_W-1:0] bits_q;

  function automatic logic [OFS_W-1:0] preset_val(input logic [1:0] sel);
    case (sel)
      2'd0:    preset_val = OFS_W'(PRESET_LO);
      2'd1:    preset_val = OFS_W'(PRESET_MID);
      default: preset_val = OFS_W'(PRESET_HI);
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      mode_q   <= LOAD_PRESET;
      half_q   <= 1'b0;
      done_q   <= 1'b0;
      y_q      <= '0;
      x_q      <= '0;
      bits_q   <= '0;
    end else if (!locked_q) begin
      locked_q <= 1'b1;
      if (!cfg_ext_i) begin
        mode_q <= LOAD_PRESET;
        y_q    <= preset_val(cfg_sel_i);
        x_q    <= preset_val(cfg_sel_i);
        done_q <= 1'b1;
      end else begin
        mode_q <= cfg_sel_i[0] ? LOAD_SERIAL : LOAD_PARALLEL;
      end
    end else if (!done_q) begin
      case (mode_q)
        LOAD_PARALLEL: if (wr_en_i) begin
          if (!half_q) begin
            y_q    <= wdata_i;
            half_q <= 1'b1;
          end else begin
            x_q    <= wdata_i;
            done_q <= 1'b1;
          end
        end
        LOAD_SERIAL: if (!sen_ni) begin
          // Y and X form one chain: first bit ends in Y MSB
          {y_q, x_q} <= {y_q[OFS_W-2:0], x_q, sdata_i};
          bits_q     <= bits_q + BITS_W'(1);
          if (bits_q == LAST_BIT) done_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign y_o    = y_q;
  assign x_o    = x_q;
  assign done_o = done_q;
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int unsigned DEPTH       = 1024,
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned OFS_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = OFS_W + 1
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              cfg_ext_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sen_ni,
  input  logic              sdata_i,
  input  logic [CNT_W-1:0]  wr_free_i,
  input  logic [CNT_W-1:0]  rd_used_i,
  output logic              fifo_wr_o,
  output logic              prog_done_o,
  output logic              af_n_o,
  output logic              ae_n_o
);
  logic [OFS_W-1:0] ofs_y, ofs_x;
  logic             done_w, done_r;

  fifo_level_loader #(.OFS_W(OFS_W)) u_loader (
    .clk_i    (wclk_i),
    .rst_ni   (rst_ni),
    .cfg_ext_i(cfg_ext_i),
    .cfg_sel_i(cfg_sel_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i[OFS_W-1:0]),
    .sen_ni   (sen_ni),
    .sdata_i  (sdata_i),
    .y_o      (ofs_y),
    .x_o      (ofs_x),
    .done_o   (done_w)
  );

  fifo_level_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (done_w),
    .q_o   (done_r)
  );

  fifo_level_cmp #(.OFS_W(OFS_W)) u_af (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .en_i   (done_w),
    .level_i(wr_free_i),
    .ofs_i  (ofs_y),
    .flag_no(af_n_o)
  );

  // X is static once done reaches the read domain
  fifo_level_cmp #(.OFS_W(OFS_W)) u_ae (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .en_i   (done_r),
    .level_i(rd_used_i),
    .ofs_i  (ofs_x),
    .flag_no(ae_n_o)
  );

  assign fifo_wr_o   = wr_en_i && done_w;
  assign prog_done_o = done_w;
endmodule

// File: rtl/fifo_level_flags_chk.sv
module fifo_level_flags_chk #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned DEPTH = 1024
) (
  input logic             wclk_i,
  input logic             rclk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_free_i,
  input logic [CNT_W-1:0] rd_used_i,
  input logic             fifo_wr_o,
  input logic             prog_done_o,
  input logic             af_n_o,
  input logic             ae_n_o
);
  AST_DONE_STICKY: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    prog_done_o |=> prog_done_o); // R7

  AST_AF_HELD_UNPROG: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !prog_done_o |=> !af_n_o); // R8

  AST_AF_LOW_NO_SPACE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_free_i == '0) |=> !af_n_o); // R8

  AST_AF_HIGH_ALL_FREE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (prog_done_o && wr_free_i == CNT_W'(DEPTH)) |=> af_n_o); // R8

  AST_AE_HELD_UNPROG: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !prog_done_o |=> !ae_n_o); // R9

  AST_AE_LOW_EMPTY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_used_i == '0) |=> !ae_n_o); // R9

  AST_NO_WR_UNPROG: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en_i && !prog_done_o) |-> !fifo_wr_o); // R5
endmodule

bind fifo_level_flags fifo_level_flags_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
  .wclk_i     (wclk_i),
  .rclk_i     (rclk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_free_i  (wr_free_i),
  .rd_used_i  (rd_used_i),
  .fifo_wr_o  (fifo_wr_o),
  .prog_done_o(prog_done_o),
  .af_n_o     (af_n_o),
  .ae_n_o     (ae_n_o)
);

// File: tb/fifo_level_flags_bench.sv
`timescale 1ns/1ps
module fifo_level_flags_bench;
  localparam int DEPTH = 1024;
  localparam int W     = 10;
  localparam int CW    = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ext = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic wr_en = 1'b0;
  logic [35:0] wdata = '0;
  logic sen_n = 1'b1, sd = 1'b0;
  logic [CW-1:0] free = '0, used = '0;
  logic fifo_wr, done, af_n, ae_n;

  int checks = 0, errors = 0;
  string req = "R1";

  always #4 clk = ~clk;

  fifo_level_flags u_fifo_level_flags (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n),
    .cfg_ext_i(cfg_ext), .cfg_sel_i(cfg_sel),
    .wr_en_i(wr_en), .wdata_i(wdata), .sen_ni(sen_n), .sdata_i(sd),
    .wr_free_i(free), .rd_used_i(used),
    .fifo_wr_o(fifo_wr), .prog_done_o(done), .af_n_o(af_n), .ae_n_o(ae_n)
  );

  // behavioural reference
  int m_locked, m_mode, m_y, m_x, m_done, m_half, m_bits, m_s1, m_s2, m_af, m_ae;
  longint m_stream;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_locked = 0; m_mode = 0; m_y = 0; m_x = 0; m_done = 0; m_half = 0;
      m_bits = 0; m_s1 = 0; m_s2 = 0; m_af = 0; m_ae = 0; m_stream = 0;
    end else begin
      m_af = (m_done != 0 && int'(free) > m_y) ? 1 : 0;
      m_ae = (m_s2 != 0 && int'(used) > m_x) ? 1 : 0;
      m_s2 = m_s1;
      m_s1 = m_done;
      if (m_locked == 0) begin
        m_locked = 1;
        if (!cfg_ext) begin
          m_mode = 0;
          m_y = (cfg_sel == 0) ? 8 : (cfg_sel == 1) ? 16 : 64;
          m_x = m_y;
          m_done = 1;
        end else m_mode = cfg_sel[0] ? 2 : 1;
      end else if (m_done == 0) begin
        if (m_mode == 1 && wr_en) begin
          if (m_half == 0) begin m_y = int'(wdata[W-1:0]); m_half = 1; end
          else begin m_x = int'(wdata[W-1:0]); m_done = 1; end
        end else if (m_mode == 2 && !sen_n) begin
          m_stream = (m_stream << 1) | longint'(sd);
          m_bits++;
          if (m_bits == 2 * W) begin
            m_y = int'((m_stream >> W) & ((1 << W) - 1));
            m_x = int'(m_stream & ((1 << W) - 1));
            m_done = 1;
          end
        end
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    chk("R8 af_n_o", int'(af_n), m_af);
    chk("R9 ae_n_o", int'(ae_n), m_ae);
    chk({req, " prog_done_o"}, int'(done), m_done);
    chk("R5 fifo_wr_o", int'(fifo_wr), (wr_en && m_done != 0) ? 1 : 0);
    if (!rst_n) begin
      chk("R1 reset flags", int'({af_n, ae_n, done}), 0);
    end
  end

  task automatic do_reset(input logic ext, input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0; cfg_ext = ext; cfg_sel = sel;
    wr_en = 0; sen_n = 1; free = CW'(DEPTH); used = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); // capture edge passes
  endtask

  task automatic sweep(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case ($urandom_range(0, 3))
        0: begin free = CW'(m_y); used = CW'(m_x); end
        1: begin free = CW'(m_y + 1); used = CW'(m_x + 1); end
        2: begin free = CW'(m_y == 0 ? 0 : m_y - 1); used = CW'(m_x == 0 ? 0 : m_x - 1); end
        default: begin free = CW'($urandom_range(0, DEPTH)); used = CW'($urandom_range(0, DEPTH)); end
      endcase
      wr_en = ($urandom_range(0, 1) == 1);
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pwrite(input int v);
    @(negedge clk); wr_en = 1; wdata = {26'h2AB_CDEF, 10'(v)};
    @(negedge clk); wr_en = 0;
  endtask

  task automatic sshift(input int v, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      @(negedge clk); sen_n = 0; sd = v[i];
      @(negedge clk); sen_n = 1; // idle gap
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    req = "R1";
    repeat (4) @(negedge clk);
    // R3 presets, each a distinct select code
    for (int s = 0; s < 4; s++) begin
      req = "R3";
      do_reset(1'b0, 2'(s));
      sweep(40);
    end
    // R2 pins changed after capture are ignored
    req = "R2";
    do_reset(1'b1, 2'b00);
    cfg_ext = 0; cfg_sel = 2'd2;
    repeat (5) @(negedge clk);
    // R4 parallel: then Y=200, X=55
    req = "R4";
    pwrite(200);
    repeat (3) @(negedge clk);
    pwrite(55);
    sweep(60);
    req = "R7";
    pwrite(900);
    pwrite(3);
    sweep(40);
    // R6 serial: Y=300, X=77
    req = "R6";
    do_reset(1'b1, 2'b01);
    sshift(300, W);
    sshift(77, W);
    sweep(60);
    // R7 extra serial bits ignored
    req = "R7";
    sshift(1023, 6);
    sweep(60);
    // serial with edge values Y=1023, X=0
    req = "R6";
    do_reset(1'b1, 2'b11);
    sshift(1023, W);
    sshift(0, W);
    sweep(40);
    @(negedge clk); free = '0; used = '0;
    @(negedge clk); free = CW'(DEPTH); used = CW'(DEPTH);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule